// File: doc/BRIEF.md
# Frame-Paced Countdown Timers with Tone Gate

This block keeps two small countdown timers and a seed counter that all advance on a single-cycle frame pulse, which arrives about sixty times a second from the display timing. The general timer counts down once per frame and rests at zero. The tone timer also counts down once per frame. While it still holds a nonzero count at a frame, a registered tone-enable output is raised for that frame. The seed counter moves up by one on every frame and wraps, so it can serve as a cheap random source.

A host can load either timer at any cycle and can read both counts back at any time. A debounce helper input loads the tone timer with a short preset of four frames, about 66 ms. A done flag then shows when that wait has run out, which is when the tone timer is back at zero. The tone waveform itself is produced elsewhere.

Top module: `frame_timers`

## Requirements
- R1: After reset, both timers, the seed counter and tone_en are all zero, and dbnc_done is 1.
- R2: On a cycle with frame_tick high and gen_wr low, a nonzero general count drops by exactly one, and a zero general count stays at zero.
- R3: On a cycle with frame_tick high and with neither tone_wr nor dbnc_req high, a nonzero tone count drops by exactly one, and a zero tone count stays at zero.
- R4: tone_en changes only on frame_tick cycles. On such a cycle it becomes 1 if the tone count held before that edge was nonzero, and 0 if it was zero.
- R5: The seed counter goes up by one on every frame_tick cycle, wraps from 255 to 0, and holds on all other cycles.
- R6: A host write (gen_wr or tone_wr) puts its data into that timer on the next edge, and it takes priority over a frame_tick in the same cycle.
- R7: dbnc_req loads the tone timer with 4 on the next edge and takes priority over a frame decrement. If tone_wr is high in the same cycle, the host data wins.
- R8: dbnc_done is 1 exactly when the tone count is zero, so it falls the cycle after a debounce request and rises again after the fourth following frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_tick | input | 1 | One-cycle pulse per video frame |
| gen_wr | input | 1 | Load strobe for the general timer |
| gen_wdata | input | 8 | Load value for the general timer |
| tone_wr | input | 1 | Load strobe for the tone timer |
| tone_wdata | input | 8 | Load value for the tone timer |
| dbnc_req | input | 1 | Debounce request; presets the tone timer |
| gen_count | output | 8 | Current general timer count |
| tone_count | output | 8 | Current tone timer count |
| seed | output | 8 | Frame-incremented seed value |
| tone_en | output | 1 | Tone enable, refreshed on each frame |
| dbnc_done | output | 1 | High while the tone timer is zero |

## Verification
The contested cycles are the ones where a frame pulse coincides with a load. This covers a host write on either timer, a debounce request, and a tone write together with a debounce request. The bench drives these combinations in the same cycle as frame_tick and predicts the winner from the priority order. It also checks that tone_en on that frame follows the count held before the edge, not the newly loaded value. Each cycle's expected counts, seed, tone_en and done flag are queued and compared once the edge has passed.

// File: rtl/frt_pkg.sv
package frt_pkg;

   typedef enum logic [1:0] {
      LD_NONE   = 2'd0,
      LD_HOST   = 2'd1,
      LD_PRESET = 2'd2
   } load_src_e;

   function automatic load_src_e pick_load(input logic host_wr, input logic preset_req);
      if (host_wr)
         return LD_HOST;
      else if (preset_req)
         return LD_PRESET;
      else
         return LD_NONE;
   endfunction

endpackage

// File: rtl/frt_down_timer.sv
module frt_down_timer
   import frt_pkg::*;
#(
   parameter int W          = 8,
   parameter bit HAS_PRESET = 1'b0,
   parameter int PRESET     = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         tick,
   input  logic         host_wr,
   input  logic [W-1:0] host_data,
   input  logic         preset_req,
   output logic [W-1:0] value,
   output logic         nonzero
);

   localparam logic [W-1:0] PRESET_V = W'(PRESET);
   localparam logic [W-1:0] ONE_V    = W'(1);

   logic       preset_sel;
   load_src_e  src;
   logic [W-1:0] cnt_q;
   logic [W-1:0] cnt_d;

   generate
      if (HAS_PRESET) begin : g_preset
         assign preset_sel = preset_req;
      end else begin : g_nopreset
         logic unused_req;
         assign unused_req = preset_req;
         assign preset_sel = 1'b0;
      end
   endgenerate

   assign src = pick_load(host_wr, preset_sel);

   always_comb begin
      cnt_d = cnt_q;
      unique case (src)
         LD_HOST:   cnt_d = host_data;
         LD_PRESET: cnt_d = PRESET_V;
         default: begin
            if (tick && (cnt_q != '0))
               cnt_d = cnt_q - ONE_V;
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else
         cnt_q <= cnt_d;
   end

   assign value   = cnt_q;
   assign nonzero = |cnt_q;

endmodule

// File: rtl/frt_tone_gate.sv
module frt_tone_gate (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic cnt_nonzero,
   output logic tone_en
);

   logic en_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         en_q <= 1'b0;
      else if (tick)
         en_q <= cnt_nonzero;
   end

   assign tone_en = en_q;

endmodule

// File: rtl/frt_seed_counter.sv
module frt_seed_counter #(
   parameter int W    = 8,
   parameter int STEP = 1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         tick,
   output logic [W-1:0] seed
);

   localparam logic [W-1:0] STEP_V = W'(STEP);

   logic [W-1:0] seed_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         seed_q <= '0;
      else if (tick)
         seed_q <= seed_q + STEP_V;
   end

   assign seed = seed_q;

endmodule

// File: rtl/frame_timers.sv
module frame_timers #(
   parameter int TW        = 8,
   parameter int SW        = 8,
   parameter int DBNC_LOAD = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          frame_tick,
   input  logic          gen_wr,
   input  logic [TW-1:0] gen_wdata,
   input  logic          tone_wr,
   input  logic [TW-1:0] tone_wdata,
   input  logic          dbnc_req,
   output logic [TW-1:0] gen_count,
   output logic [TW-1:0] tone_count,
   output logic [SW-1:0] seed,
   output logic          tone_en,
   output logic          dbnc_done
);

   localparam int DBNC_MAX = (1 << TW) - 1;

   generate
      if (TW < 2) begin : g_bad_tw
         $error("frame_timers: TW must be at least 2");
      end
      if (SW < 1) begin : g_bad_sw
         $error("frame_timers: SW must be at least 1");
      end
      if (DBNC_LOAD < 1 || DBNC_LOAD > DBNC_MAX) begin : g_bad_load
         $error("frame_timers: DBNC_LOAD must fit in TW bits and be nonzero");
      end
   endgenerate

   logic gen_nz;
   logic tone_nz;

   frt_down_timer #(
      .W(TW), .HAS_PRESET(1'b0), .PRESET(1)
   ) u_gen (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick       (frame_tick),
      .host_wr    (gen_wr),
      .host_data  (gen_wdata),
      .preset_req (1'b0),
      .value      (gen_count),
      .nonzero    (gen_nz)
   );

   frt_down_timer #(
      .W(TW), .HAS_PRESET(1'b1), .PRESET(DBNC_LOAD)
   ) u_tone (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick       (frame_tick),
      .host_wr    (tone_wr),
      .host_data  (tone_wdata),
      .preset_req (dbnc_req),
      .value      (tone_count),
      .nonzero    (tone_nz)
   );

   frt_tone_gate u_gate (
      .clk         (clk),
      .rst_n       (rst_n),
      .tick        (frame_tick),
      .cnt_nonzero (tone_nz),
      .tone_en     (tone_en)
   );

   frt_seed_counter #(
      .W(SW), .STEP(1)
   ) u_seed (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (frame_tick),
      .seed  (seed)
   );

   logic unused_gen_nz;
   assign unused_gen_nz = gen_nz;
   assign dbnc_done     = ~tone_nz;

endmodule

// File: rtl/frame_timers_chk.sv
module frame_timers_chk #(
   parameter int TW        = 8,
   parameter int SW        = 8,
   parameter int DBNC_LOAD = 4
) (
   input logic          clk,
   input logic          rst_n,
   input logic          frame_tick,
   input logic          gen_wr,
   input logic [TW-1:0] gen_wdata,
   input logic          tone_wr,
   input logic [TW-1:0] tone_wdata,
   input logic          dbnc_req,
   input logic [TW-1:0] gen_count,
   input logic [TW-1:0] tone_count,
   input logic [SW-1:0] seed,
   input logic          tone_en,
   input logic          dbnc_done
);

   // R2
   gen_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_tick && !gen_wr && gen_count != '0) |=> gen_count == TW'($past(gen_count) - TW'(1)));

   // R2
   gen_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_tick && !gen_wr && gen_count == '0) |=> gen_count == '0);

   // R3
   tone_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!tone_wr && !dbnc_req && tone_count == '0) |=> tone_count == '0);

   // R4
   tone_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_tick |=> $stable(tone_en));

   // R4
   tone_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_tick && tone_count != '0) |=> tone_en);

   // R5
   seed_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      frame_tick |=> seed == SW'($past(seed) + SW'(1)));

   // R6
   gen_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      gen_wr |=> gen_count == $past(gen_wdata));

   // R6
   tone_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tone_wr |=> tone_count == $past(tone_wdata));

   // R7
   dbnc_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dbnc_req && !tone_wr) |=> tone_count == TW'(DBNC_LOAD));

   // R8
   dbnc_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dbnc_req && !tone_wr) |=> !dbnc_done);

endmodule

bind frame_timers frame_timers_chk #(
   .TW(TW), .SW(SW), .DBNC_LOAD(DBNC_LOAD)
) u_chk (.*);

// File: tb/sim_frame_timers.sv
`timescale 1ns/1ps
module sim_frame_timers;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       frame_tick = 1'b0;
   logic       gen_wr = 1'b0;
   logic [7:0] gen_wdata = '0;
   logic       tone_wr = 1'b0;
   logic [7:0] tone_wdata = '0;
   logic       dbnc_req = 1'b0;
   logic [7:0] gen_count;
   logic [7:0] tone_count;
   logic [7:0] seed;
   logic       tone_en;
   logic       dbnc_done;

   always #5 clk = ~clk;

   frame_timers u0 (
      .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick),
      .gen_wr(gen_wr), .gen_wdata(gen_wdata),
      .tone_wr(tone_wr), .tone_wdata(tone_wdata),
      .dbnc_req(dbnc_req),
      .gen_count(gen_count), .tone_count(tone_count), .seed(seed),
      .tone_en(tone_en), .dbnc_done(dbnc_done)
   );

   typedef struct packed {
      logic [7:0] g;
      logic [7:0] t;
      logic [7:0] s;
      logic       en;
      logic       done;
   } exp_t;

   exp_t q[$];
   int   n_checks = 0;
   int   n_fail = 0;

   logic [7:0] m_g = 0, m_t = 0, m_s = 0;
   logic       m_en = 0;

   task automatic chk8(input string tag, input logic [7:0] act, input logic [7:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   // driver: applies one cycle of stimulus and queues the predicted state
   task automatic step(input logic tk, input logic gw, input logic [7:0] gd,
                       input logic tw, input logic [7:0] td, input logic dr);
      exp_t e;
      @(negedge clk);
      frame_tick = tk; gen_wr = gw; gen_wdata = gd;
      tone_wr = tw; tone_wdata = td; dbnc_req = dr;
      if (tk) m_en = (m_t != 0);
      if (gw) m_g = gd;
      else if (tk && m_g != 0) m_g = m_g - 1;
      if (tw) m_t = td;
      else if (dr) m_t = 8'd4;
      else if (tk && m_t != 0) m_t = m_t - 1;
      if (tk) m_s = m_s + 1;
      e.g = m_g; e.t = m_t; e.s = m_s; e.en = m_en; e.done = (m_t == 0);
      q.push_back(e);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0);
   endtask

   // monitor: compares after each edge
   always @(posedge clk) begin
      #1;
      if (q.size() > 0) begin
         exp_t e;
         e = q.pop_front();
         chk8("R2/R6 gen_count", gen_count, e.g);
         chk8("R3/R6/R7 tone_count", tone_count, e.t);
         chk8("R5 seed", seed, e.s);
         chk8("R4 tone_en", {7'd0, tone_en}, {7'd0, e.en});
         chk8("R8 dbnc_done", {7'd0, dbnc_done}, {7'd0, e.done});
      end
   end

   initial begin
      #2_000_000;
      n_checks++; n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset values
      chk8("R1 gen_count", gen_count, 0);
      chk8("R1 tone_count", tone_count, 0);
      chk8("R1 seed", seed, 0);
      chk8("R1 tone_en", {7'd0, tone_en}, 0);
      chk8("R1 dbnc_done", {7'd0, dbnc_done}, 1);
      rst_n = 1'b1;
      idle(2);
      // R2: ticks on zero hold at zero; then load and count down past zero
      step(1, 0, 0, 0, 0, 0);
      step(0, 1, 8'd3, 0, 0, 0);
      for (int i = 0; i < 5; i++) begin step(1, 0, 0, 0, 0, 0); idle(2); end
      // R3 / R4: tone timer countdown gates tone_en
      step(0, 0, 0, 1, 8'd2, 0);
      idle(3);
      for (int i = 0; i < 4; i++) begin step(1, 0, 0, 0, 0, 0); idle(1); end
      // R6: writes coincide with a frame tick
      step(1, 1, 8'd9, 1, 8'd7, 0);
      step(1, 1, 8'd0, 0, 0, 0);
      // R7: debounce request, then with tick, then against tone_wr
      step(0, 0, 0, 0, 0, 1);
      idle(2);
      for (int i = 0; i < 6; i++) step(1, 0, 0, 0, 0, 0);
      step(1, 0, 0, 0, 0, 1);
      step(1, 0, 0, 1, 8'd20, 1);
      step(1, 0, 0, 0, 0, 0);
      // R8: run the tone timer down to zero with spaced ticks
      step(0, 0, 0, 0, 0, 1);
      for (int i = 0; i < 5; i++) begin step(1, 0, 0, 0, 0, 0); idle(1); end
      // R5: seed wraps
      for (int i = 0; i < 260; i++) step(1, 0, 0, 0, 0, 0);
      step(1, 1, 8'd255, 0, 0, 0);
      idle(3);
      wait (q.size() == 0);
      @(negedge clk);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

endmodule